// File: doc/BRIEF.md
# Dual-Rank SDRAM Power-State Manager

This block keeps track of the low-power state of two SDRAM ranks and sequences the moves between states. Each rank is a small state machine with three states: RK_ACTIVE, RK_SELFREF and RK_DEEPPD. A register-side command port moves one rank at a time. An access request from the arbiter wakes a rank that is in self-refresh. A rank in deep power-down wakes only when it receives an explicit exit command. Each rank's CKE is high only while that rank is active. The external memory clock is turned off only when every rank is in a low-power state.

A second state machine runs the hardware idle handshake with the power controller. Its states are IC_RUN, IC_PARK, IC_IDLE and IC_WAKE.
- IC_RUN to IC_PARK: taken when an idle request arrives and idle parking is enabled.
- In IC_PARK: every active rank is sent into self-refresh. The memory clock is then gated.
- IC_PARK to IC_IDLE: taken once all ranks are low, which raises the acknowledge.
- Leaving IC_IDLE: taken when the request drops. The acknowledge falls on the next edge. The block goes either straight to IC_RUN or to IC_WAKE.
- In IC_WAKE: access grants are held back until the DLL is ready. Readiness is either the DLL lock input or a fixed count of `WAKE_CYCLES` (500), chosen by configuration.
- SDR memory, or a DLL in fixed-delay mode, skips IC_WAKE.

Top module: `sdram_pwr_mgr`

## Requirements
- R1: After reset both ranks read active: `rank_state` = 0000, `cke` = 11, `ext_clk_en` = 1, `idle_ack` = 0. Rank r owns bits [2r+1:2r] of `rank_state`, encoded 00 active, 01 self-refresh, 10 deep power-down.
- R2: A command with `cmd_valid` high acts on the rank `cmd_rank` and on the clock edge that samples it. The `cmd_op` codes are:
  - 01: enter self-refresh, accepted only from active.
  - 10: enter deep power-down, accepted from active or self-refresh.
  - 11: exit.

  The other rank is left unchanged.
- R3: `cke[r]` is low exactly while rank r is in self-refresh or deep power-down.
- R4: A rank in self-refresh leaves it on the edge that samples its `acc_req` bit, provided the idle machine is in IC_RUN or IC_WAKE. The other rank keeps its state.
- R4 (grant): `acc_grant[r]` is high only when `acc_req[r]` is high, the rank is active and the idle machine is in IC_RUN.
- R5: A rank in deep power-down stays there when it is accessed and when it receives an enter-self-refresh command. It has no grant.
- R6: The exit command returns a rank to active from either low-power state whatever the idle machine is doing, including while the idle acknowledge is high.
- R7: `ext_clk_en` is low only while both ranks are low-power, and either `cfg_clk_off_en` is set or the idle machine is in IC_PARK or IC_IDLE.
- R8: With `cfg_idle_sr_en` set, an idle request sampled on edge E0 gives this sequence:
  - edge E1: both ranks enter self-refresh, and `cke` and `ext_clk_en` go low.
  - edge E2: `idle_ack` rises.

  With `cfg_idle_sr_en` clear, the request is ignored.
- R9: `idle_ack` falls on the first edge that samples `idle_req` low, and any wake-up wait begins on that same edge.
- R10: With `cfg_mem_ddr`=1, `cfg_dll_track`=1 and `cfg_wake_delay`=0, no grant is given after idle until `dll_lock` is sampled high. The grant appears on the following cycle.
- R11: With DDR, tracking and `cfg_wake_delay`=1, grants are held for exactly `WAKE_CYCLES` cycles after the acknowledge falls, and `dll_lock` is ignored.
- R12: With SDR memory (`cfg_mem_ddr`=0) or a fixed-delay DLL (`cfg_dll_track`=0), there is no wait. An access held from the acknowledge fall is granted two cycles later, which is the self-refresh exit cycle plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_idle_sr_en | input | 1 | Allow an idle request to park the memory in self-refresh |
| cfg_wake_delay | input | 1 | Use a fixed wake count instead of DLL lock |
| cfg_mem_ddr | input | 1 | 1 = DDR memory, 0 = SDR |
| cfg_dll_track | input | 1 | 1 = DLL in tracking mode, 0 = fixed delay |
| cfg_clk_off_en | input | 1 | Allow the memory clock off when all ranks are low-power |
| cmd_valid | input | 1 | Manual command strobe |
| cmd_rank | input | 1 | Target rank of the manual command |
| cmd_op | input | 2 | 01 self-refresh, 10 deep power-down, 11 exit |
| idle_req | input | 1 | Idle request from the power controller |
| idle_ack | output | 1 | Idle acknowledge |
| acc_req | input | 2 | Per-rank access request |
| acc_grant | output | 2 | Per-rank access grant |
| dll_lock | input | 1 | DLL lock status |
| cke | output | 2 | Per-rank clock enable |
| ext_clk_en | output | 1 | External memory clock enable |
| rank_state | output | 4 | Per-rank state, 2 bits per rank |

## Verification
The bench checks the asymmetric exit rules in two ways:
- An access to a self-refresh rank must wake only that rank. A design that woke both ranks would leave the neighbour with CKE high.
- A deep power-down rank is hammered with accesses and with an enter-self-refresh command. A design that treated it like self-refresh would wake it or change its state.

The bench times the idle handshake to the edge. A design that raised the acknowledge before the clock was gated would show `idle_ack` high while `ext_clk_en` is still high. For the wake path, the bench holds `dll_lock` low in lock mode and holds it high in delay mode, then counts the exact cycle of the first grant. A design that mixed up the two sources, or was off by one in the 500-cycle count, would grant early or late. Finally, the bench sends a manual exit while the acknowledge is high, which catches a design that gates the exit on the idle state.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;
    typedef enum logic [1:0] {
        RK_ACTIVE  = 2'b00,
        RK_SELFREF = 2'b01,
        RK_DEEPPD  = 2'b10
    } rank_st_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SREF = 2'b01,
        OP_DPD  = 2'b10,
        OP_EXIT = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        IC_RUN  = 2'b00,
        IC_PARK = 2'b01,
        IC_IDLE = 2'b10,
        IC_WAKE = 2'b11
    } idle_st_e;
endpackage

// File: rtl/spm_rank_fsm.sv
module spm_rank_fsm
    import sdram_pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_hit,
    input  cmd_op_e  cmd_op,
    input  logic     park_req,
    input  logic     acc_req,
    input  logic     auto_exit_ok,
    output rank_st_e state,
    output logic     cke
);
    rank_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RK_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RK_ACTIVE: begin
                if (cmd_hit && cmd_op == OP_SREF)     state_d = RK_SELFREF;
                else if (cmd_hit && cmd_op == OP_DPD) state_d = RK_DEEPPD;
                else if (park_req)                    state_d = RK_SELFREF;
            end
            RK_SELFREF: begin
                if (cmd_hit && cmd_op == OP_EXIT)     state_d = RK_ACTIVE;
                else if (cmd_hit && cmd_op == OP_DPD) state_d = RK_DEEPPD;
                else if (acc_req && auto_exit_ok)     state_d = RK_ACTIVE;
            end
            RK_DEEPPD: begin
                if (cmd_hit && cmd_op == OP_EXIT)     state_d = RK_ACTIVE;
            end
            default: state_d = RK_ACTIVE;
        endcase
    end

    always_comb begin
        state = state_q;
        cke   = (state_q == RK_ACTIVE);
    end
endmodule

// File: rtl/spm_idle_ctl.sv
module spm_idle_ctl
    import sdram_pwr_pkg::*;
#(
    parameter int WAKE_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_req,
    input  logic cfg_idle_sr_en,
    input  logic cfg_mem_ddr,
    input  logic cfg_dll_track,
    input  logic cfg_wake_delay,
    input  logic dll_lock,
    input  logic all_low,
    output logic park_req,
    output logic clk_park,
    output logic idle_ack,
    output logic grant_hold,
    output logic auto_exit_ok
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYCLES - 1);

    idle_st_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             need_wait, wake_done;

    assign need_wait = cfg_mem_ddr && cfg_dll_track;
    assign wake_done = cfg_wake_delay ? (cnt_q == LAST) : dll_lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IC_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == IC_WAKE) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IC_RUN:  if (idle_req && cfg_idle_sr_en) state_d = IC_PARK;
            IC_PARK: if (all_low)                    state_d = IC_IDLE;
            IC_IDLE: if (!idle_req)                  state_d = need_wait ? IC_WAKE : IC_RUN;
            IC_WAKE: if (wake_done)                  state_d = IC_RUN;
            default: state_d = IC_RUN;
        endcase
    end

    always_comb begin
        park_req     = (state_q == IC_PARK);
        clk_park     = (state_q == IC_PARK) || (state_q == IC_IDLE);
        idle_ack     = (state_q == IC_IDLE);
        grant_hold   = (state_q != IC_RUN);
        auto_exit_ok = (state_q == IC_RUN) || (state_q == IC_WAKE);
    end
endmodule

// File: rtl/sdram_pwr_mgr.sv
module sdram_pwr_mgr
    import sdram_pwr_pkg::*;
#(
    parameter int NUM_RANKS   = 2,
    parameter int WAKE_CYCLES = 500
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_idle_sr_en,
    input  logic                         cfg_wake_delay,
    input  logic                         cfg_mem_ddr,
    input  logic                         cfg_dll_track,
    input  logic                         cfg_clk_off_en,
    input  logic                         cmd_valid,
    input  logic [$clog2(NUM_RANKS)-1:0] cmd_rank,
    input  logic [1:0]                   cmd_op,
    input  logic                         idle_req,
    output logic                         idle_ack,
    input  logic [NUM_RANKS-1:0]         acc_req,
    output logic [NUM_RANKS-1:0]         acc_grant,
    input  logic                         dll_lock,
    output logic [NUM_RANKS-1:0]         cke,
    output logic                         ext_clk_en,
    output logic [2*NUM_RANKS-1:0]       rank_state
);
    localparam int RW = $clog2(NUM_RANKS);

    logic park_req, clk_park, grant_hold, auto_exit_ok, all_low;

    assign all_low = ~|cke;

    spm_idle_ctl #(.WAKE_CYCLES(WAKE_CYCLES)) idle_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .idle_req       (idle_req),
        .cfg_idle_sr_en (cfg_idle_sr_en),
        .cfg_mem_ddr    (cfg_mem_ddr),
        .cfg_dll_track  (cfg_dll_track),
        .cfg_wake_delay (cfg_wake_delay),
        .dll_lock       (dll_lock),
        .all_low        (all_low),
        .park_req       (park_req),
        .clk_park       (clk_park),
        .idle_ack       (idle_ack),
        .grant_hold     (grant_hold),
        .auto_exit_ok   (auto_exit_ok)
    );

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        rank_st_e st;
        spm_rank_fsm rank_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .cmd_hit      (cmd_valid && (cmd_rank == RW'(r))),
            .cmd_op       (cmd_op_e'(cmd_op)),
            .park_req     (park_req),
            .acc_req      (acc_req[r]),
            .auto_exit_ok (auto_exit_ok),
            .state        (st),
            .cke          (cke[r])
        );
        assign rank_state[2*r +: 2] = st;
        assign acc_grant[r] = acc_req[r] && cke[r] && !grant_hold;
    end

    assign ext_clk_en = !(all_low && (cfg_clk_off_en || clk_park));
endmodule

// File: rtl/sdram_pwr_mgr_chk.sv
module sdram_pwr_mgr_chk #(
    parameter int NUM_RANKS = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_wake_delay,
    input logic                         cfg_mem_ddr,
    input logic                         cfg_dll_track,
    input logic                         cmd_valid,
    input logic [$clog2(NUM_RANKS)-1:0] cmd_rank,
    input logic [1:0]                   cmd_op,
    input logic                         idle_req,
    input logic                         idle_ack,
    input logic [NUM_RANKS-1:0]         acc_req,
    input logic [NUM_RANKS-1:0]         acc_grant,
    input logic [NUM_RANKS-1:0]         cke,
    input logic                         ext_clk_en,
    input logic [2*NUM_RANKS-1:0]       rank_state
);
    localparam int RW = $clog2(NUM_RANKS);

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
        // R3
        cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rank_state[2*r +: 2] != 2'b00) |-> !cke[r]);

        // R5
        dpd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rank_state[2*r +: 2] == 2'b10 &&
             !(cmd_valid && cmd_rank == RW'(r) && cmd_op == 2'b11))
            |=> rank_state[2*r +: 2] == 2'b10);

        // R4
        grant_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            acc_grant[r] |-> (acc_req[r] && rank_state[2*r +: 2] == 2'b00));
    end

    // R7
    clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_clk_en |-> (cke == '0));

    // R8
    ack_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_ack) |-> $past(!ext_clk_en));

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack && !idle_req) |=> !idle_ack);

    // R10
    lock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(idle_ack) && cfg_mem_ddr && cfg_dll_track && !cfg_wake_delay)
        |-> (acc_grant == '0));
endmodule

bind sdram_pwr_mgr sdram_pwr_mgr_chk #(.NUM_RANKS(NUM_RANKS)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wake_delay (cfg_wake_delay),
    .cfg_mem_ddr    (cfg_mem_ddr),
    .cfg_dll_track  (cfg_dll_track),
    .cmd_valid      (cmd_valid),
    .cmd_rank       (cmd_rank),
    .cmd_op         (cmd_op),
    .idle_req       (idle_req),
    .idle_ack       (idle_ack),
    .acc_req        (acc_req),
    .acc_grant      (acc_grant),
    .cke            (cke),
    .ext_clk_en     (ext_clk_en),
    .rank_state     (rank_state)
);

// File: tb/sdram_pwr_mgr_tb_top.sv
module sdram_pwr_mgr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE = 500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_idle_sr_en = 1'b0, cfg_wake_delay = 1'b0, cfg_mem_ddr = 1'b0;
    logic       cfg_dll_track = 1'b0, cfg_clk_off_en = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [0:0] cmd_rank = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic       idle_req = 1'b0, dll_lock = 1'b0;
    logic [1:0] acc_req = 2'b00;
    logic       idle_ack, ext_clk_en;
    logic [1:0] acc_grant, cke;
    logic [3:0] rank_state;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_pwr_mgr #(.NUM_RANKS(2), .WAKE_CYCLES(WAKE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_idle_sr_en(cfg_idle_sr_en), .cfg_wake_delay(cfg_wake_delay),
        .cfg_mem_ddr(cfg_mem_ddr), .cfg_dll_track(cfg_dll_track),
        .cfg_clk_off_en(cfg_clk_off_en),
        .cmd_valid(cmd_valid), .cmd_rank(cmd_rank), .cmd_op(cmd_op),
        .idle_req(idle_req), .idle_ack(idle_ack),
        .acc_req(acc_req), .acc_grant(acc_grant), .dll_lock(dll_lock),
        .cke(cke), .ext_clk_en(ext_clk_en), .rank_state(rank_state)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic rank, input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_rank = rank; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic set_cfg(input logic ddr, input logic trk, input logic dly);
        cfg_mem_ddr = ddr; cfg_dll_track = trk; cfg_wake_delay = dly;
        cfg_idle_sr_en = 1'b1; cfg_clk_off_en = 1'b0;
    endtask

    task automatic park_idle();
        @(negedge clk);
        idle_req = 1'b1;
        step(); step(); step();
    endtask

    task automatic t_reset();
        check("R1 state", rank_state, 4'b0000);
        check("R1 cke", cke, 2'b11);
        check("R1 clk", ext_clk_en, 1'b1);
        check("R1 ack", idle_ack, 1'b0);
    endtask

    task automatic t_manual();
        send_cmd(1'b1, 2'b01);
        check("R2 rank1 sref", rank_state, 4'b0100);
        check("R3 cke rank1 low", cke, 2'b01);
        send_cmd(1'b0, 2'b10);
        check("R2 rank0 dpd", rank_state, 4'b0110);
        check("R3 cke both low", cke, 2'b00);
        check("R7 clk on while disabled", ext_clk_en, 1'b1);
        cfg_clk_off_en = 1'b1;
        step();
        check("R7 clk off all low", ext_clk_en, 1'b0);
        send_cmd(1'b0, 2'b01);
        check("R5 sref cmd ignored in dpd", rank_state, 4'b0110);
        send_cmd(1'b0, 2'b11);
        check("R5 dpd exit by cmd", rank_state, 4'b0100);
        check("R7 clk on one active", ext_clk_en, 1'b1);
        send_cmd(1'b1, 2'b11);
        check("R2 rank1 exit", rank_state, 4'b0000);
        cfg_clk_off_en = 1'b0;
    endtask

    task automatic t_sref_access();
        send_cmd(1'b0, 2'b01);
        send_cmd(1'b1, 2'b01);
        check("R2 both sref", rank_state, 4'b0101);
        @(negedge clk);
        acc_req = 2'b01;
        step();
        check("R4 only rank0 wakes", rank_state, 4'b0100);
        check("R4 grant rank0", acc_grant, 2'b01);
        acc_req = 2'b00;
        send_cmd(1'b1, 2'b11);
    endtask

    task automatic t_dpd_access();
        int bad = 0;
        send_cmd(1'b1, 2'b10);
        @(negedge clk);
        acc_req = 2'b10;
        for (int i = 0; i < 5; i++) begin
            step();
            if (rank_state !== 4'b1000 || acc_grant !== 2'b00) bad++;
        end
        check("R5 dpd ignores access", bad, 0);
        acc_req = 2'b00;
        send_cmd(1'b1, 2'b11);
        check("R5 dpd left by exit", rank_state, 4'b0000);
    endtask

    task automatic t_idle_disabled();
        int bad = 0;
        set_cfg(1'b0, 1'b0, 1'b0);
        cfg_idle_sr_en = 1'b0;
        @(negedge clk);
        idle_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            if (idle_ack !== 1'b0 || cke !== 2'b11) bad++;
        end
        check("R8 idle ignored when disabled", bad, 0);
        idle_req = 1'b0;
        step();
    endtask

    task automatic t_idle_seq(input string tag, input logic ddr, input logic trk);
        set_cfg(ddr, trk, 1'b0);
        @(negedge clk);
        idle_req = 1'b1;
        step();
        check("R8 e0 cke high", cke, 2'b11);
        check("R8 e0 ack low", idle_ack, 1'b0);
        step();
        check("R8 e1 ranks sref", rank_state, 4'b0101);
        check("R8 e1 clk off", ext_clk_en, 1'b0);
        check("R8 e1 ack still low", idle_ack, 1'b0);
        step();
        check("R8 e2 ack", idle_ack, 1'b1);
        idle_req = 1'b0;
        acc_req = 2'b01;
        step();
        check("R9 ack drop", idle_ack, 1'b0);
        check({tag, " no grant yet"}, acc_grant, 2'b00);
        step();
        check({tag, " grant no wait"}, acc_grant, 2'b01);
        check("R4 rank1 stays sref", rank_state, 4'b0100);
        acc_req = 2'b00;
        send_cmd(1'b1, 2'b11);
    endtask

    task automatic t_idle_lock();
        int bad = 0;
        set_cfg(1'b1, 1'b1, 1'b0);
        dll_lock = 1'b0;
        park_idle();
        check("R10 ack high", idle_ack, 1'b1);
        idle_req = 1'b0;
        acc_req = 2'b01;
        for (int i = 0; i < 4; i++) begin
            step();
            if (acc_grant !== 2'b00) bad++;
        end
        check("R10 held while unlocked", bad, 0);
        dll_lock = 1'b1;
        step();
        check("R10 grant after lock", acc_grant, 2'b01);
        acc_req = 2'b00;
        dll_lock = 1'b0;
        send_cmd(1'b1, 2'b11);
    endtask

    task automatic t_idle_delay();
        int bad = 0;
        set_cfg(1'b1, 1'b1, 1'b1);
        dll_lock = 1'b1;
        park_idle();
        idle_req = 1'b0;
        acc_req = 2'b01;
        for (int i = 1; i <= WAKE; i++) begin
            step();
            if (acc_grant !== 2'b00) bad++;
        end
        check("R11 held full delay, lock ignored", bad, 0);
        step();
        check("R11 grant after delay", acc_grant, 2'b01);
        acc_req = 2'b00;
        dll_lock = 1'b0;
        send_cmd(1'b1, 2'b11);
    endtask

    task automatic t_exit_in_idle();
        set_cfg(1'b0, 1'b0, 1'b0);
        park_idle();
        check("R6 ack before exit", idle_ack, 1'b1);
        send_cmd(1'b1, 2'b11);
        check("R6 exit during idle", rank_state, 4'b0001);
        check("R6 cke rank1 up", cke, 2'b10);
        check("R7 clk back on", ext_clk_en, 1'b1);
        idle_req = 1'b0;
        step();
        send_cmd(1'b0, 2'b11);
        check("R6 all active", rank_state, 4'b0000);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_manual();
        t_sref_access();
        t_dpd_access();
        t_idle_disabled();
        t_idle_seq("R12 sdr", 1'b0, 1'b1);
        t_idle_seq("R12 fixed dll", 1'b1, 1'b0);
        t_idle_lock();
        t_idle_delay();
        t_exit_in_idle();
        report();
    end
endmodule